// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block is a serial-bus master that walks a serial analog-to-digital converter through a list of channels and hands back one sample per channel. A single-cycle start pulse begins a scan. At that moment the block captures a 16-bit channel-enable mask and a range-select bit. It then sends one 16-bit command frame for each enabled channel, in ascending channel order.

The converter returns each result two frames after the command that asked for it. The block therefore appends two trailing frames to every scan. It pairs each returned word with the command issued two frames earlier and checks that the channel number the converter echoes is the one it expects. Each sample appears on a one-cycle valid strobe, together with the sample value, the channel it belongs to and a mismatch flag.

The serial clock idles low. Data is sent most significant bit first. The chip select is released between frames. The width of the sample is a parameter: 12, 10 or 8 bits.

Top module: `adc_scan_seq`

## Requirements
- R1: Every command frame has bit 12 set (manual channel select), bit 11 set (settings write), the channel number in bits 10:7, the range-select bit captured at start in bit 6, and all other bits zero.
- R2: Command frames go out in ascending channel order, exactly one for each set bit of the captured mask.
- R3: A scan with N enabled channels, N of two or more, uses exactly N+2 frames, and the two trailing frames carry all-zero words.
- R4: A scan with one enabled channel uses exactly three frames. The second frame repeats the command of the first, and the third frame is all zero.
- R5: The serial clock is low whenever chip select (active low) is high. MOSI changes only while the serial clock is low. MISO is sampled on the rising edge, most significant bit first. Chip select stays high for at least two system clocks between frames.
- R6: The k-th output sample is taken from the word returned in frame k+2. Its channel output is the channel of the k-th command, and its data output is returned bits 11 down to 12-SAMPLE_W. No sample is output for the first two frames.
- R7: The error flag of a sample is high exactly when bits 15:12 of its returned word differ from the channel output of that sample.
- R8: Busy rises in the cycle after an accepted start and falls one cycle after the valid strobe of the last sample. A start pulse that arrives while busy is high is ignored.
- R9: A start pulse with an all-zero mask produces no frame and no sample, and busy stays low.
- R10: Changes to the mask and range inputs after the start pulse have no effect on the running scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a scan |
| ch_mask | input | 16 | Channel-enable mask, captured at start |
| wide_range | input | 1 | Selects the double input range, captured at start |
| busy | output | 1 | High while a scan is in progress |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Chip select to the converter, active low |
| mosi | output | 1 | Serial command data to the converter |
| miso | input | 1 | Serial result data from the converter |
| smp_valid | output | 1 | One-cycle strobe marking a sample |
| smp_data | output | SAMPLE_W | Sample value |
| smp_chan | output | 4 | Channel the sample belongs to |
| smp_err | output | 1 | Echoed channel differs from smp_chan |

## Verification
A wrong pending mask or a wrong pick of the next channel shows up within the frame in question: it appears as a wrong or missing command word on MOSI. A slip in the two-frame channel history affects every sample that follows it. Each such sample leaves with the wrong channel number and with its error flag set against a correctly echoing converter model. A wrong trailing-frame count changes the number of frames and the time at which busy falls, so it shows by the end of the scan. Corrupting the echo in chosen frames shows whether the error flag is tied to the right sample and to no other.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int FRAME_W = 16;
    localparam int CHAN_W  = 4;
    localparam int NUM_CH  = 1 << CHAN_W;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_LOW,
        SP_HIGH,
        SP_GAP
    } spi_state_t;

    // Outgoing command word layout, most significant field first.
    typedef struct packed {
        logic [2:0]        rsv_hi;
        logic              manual_sel;
        logic              prog_en;
        logic [CHAN_W-1:0] chan;
        logic              dbl_range;
        logic [5:0]        rsv_lo;
    } cmd_word_t;

    // Returned word layout: echoed channel above a left-justified sample.
    typedef struct packed {
        logic [CHAN_W-1:0] echo;
        logic [11:0]       body;
    } resp_word_t;

    function automatic logic [FRAME_W-1:0] make_cmd(input logic [CHAN_W-1:0] ch,
                                                    input logic dbl);
        cmd_word_t c;
        c            = '0;
        c.manual_sel = 1'b1;
        c.prog_en    = 1'b1;
        c.chan       = ch;
        c.dbl_range  = dbl;
        return c;
    endfunction

endpackage

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx
);
    // below[i] is set when some lower bit of the mask is set.
    logic [N-1:0] below;
    logic [N-1:0] lowest;

    assign below[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_prefix
            assign below[g] = below[g-1] | mask[g-1];
        end
    endgenerate

    assign lowest = mask & ~below;
    assign found  = |mask;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (lowest[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/adc_scan_spi.sv
module adc_scan_spi
    import adc_scan_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int CS_GAP    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    input  logic               miso,
    output logic               done,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int CMAX = (SCLK_HALF > CS_GAP) ? SCLK_HALF : CS_GAP;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int BW   = $clog2(FRAME_W);

    spi_state_t         st;
    logic [CW-1:0]      cnt;
    logic [BW-1:0]      bitn;
    logic [FRAME_W-1:0] sr;
    logic [FRAME_W-1:0] rx;

    assign mosi    = ~cs_n & sr[FRAME_W-1];
    assign rx_word = rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SP_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sr   <= '0;
            rx   <= '0;
            sclk <= 1'b0;
            cs_n <= 1'b1;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SP_IDLE: begin
                    if (go) begin
                        cs_n <= 1'b0;
                        sr   <= tx_word;
                        cnt  <= '0;
                        bitn <= '0;
                        st   <= SP_LOW;
                    end
                end
                SP_LOW: begin
                    if (cnt == CW'(SCLK_HALF - 1)) begin
                        cnt  <= '0;
                        sclk <= 1'b1;
                        rx   <= {rx[FRAME_W-2:0], miso};
                        st   <= SP_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SP_HIGH: begin
                    if (cnt == CW'(SCLK_HALF - 1)) begin
                        cnt  <= '0;
                        sclk <= 1'b0;
                        if (bitn == BW'(FRAME_W - 1)) begin
                            cs_n <= 1'b1;
                            st   <= SP_GAP;
                        end else begin
                            bitn <= bitn + 1'b1;
                            sr   <= {sr[FRAME_W-2:0], 1'b0};
                            st   <= SP_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(CS_GAP - 1)) begin
                        cnt  <= '0;
                        done <= 1'b1;
                        st   <= SP_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    p_cs_gap_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);

endmodule

// File: rtl/adc_scan_resp.sv
module adc_scan_resp
    import adc_scan_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scan_begin,
    input  logic                frame_done,
    input  logic [FRAME_W-1:0]  rx_word,
    input  logic [CHAN_W-1:0]   frame_chan,
    output logic                smp_valid,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic [CHAN_W-1:0]   smp_chan,
    output logic                smp_err
);
    resp_word_t        rw;
    logic [CHAN_W-1:0] hist0;
    logic [CHAN_W-1:0] hist1;
    logic [1:0]        seen;

    assign rw = resp_word_t'(rx_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist0     <= '0;
            hist1     <= '0;
            seen      <= '0;
            smp_valid <= 1'b0;
            smp_data  <= '0;
            smp_chan  <= '0;
            smp_err   <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            if (scan_begin) begin
                seen <= '0;
            end else if (frame_done) begin
                if (seen == 2'd2) begin
                    smp_valid <= 1'b1;
                    smp_chan  <= hist1;
                    smp_data  <= rw.body[11 -: SAMPLE_W];
                    smp_err   <= (rw.echo != hist1);
                end else begin
                    seen <= seen + 1'b1;
                end
                hist1 <= hist0;
                hist0 <= frame_chan;
            end
        end
    end

    p_lag_two_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_done && seen != 2'd2) |=> !smp_valid);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int SCLK_HALF = 2,
    parameter int CS_GAP    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [15:0]         ch_mask,
    input  logic                wide_range,
    output logic                busy,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    input  logic                miso,
    output logic                smp_valid,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic [3:0]          smp_chan,
    output logic                smp_err
);
    seq_state_t         st;
    logic [NUM_CH-1:0]  pend;
    logic               rng_q;
    logic               single_q;
    logic [1:0]         trail;
    logic [CHAN_W-1:0]  cur_ch;
    logic               found;
    logic [CHAN_W-1:0]  pick_idx;
    logic               scan_begin;
    logic               frame_go;
    logic [FRAME_W-1:0] frame_word;
    logic               frame_done;
    logic [FRAME_W-1:0] frame_rx;

    adc_scan_pick #(.N(NUM_CH), .IW(CHAN_W)) u_pick (
        .mask  (pend),
        .found (found),
        .idx   (pick_idx)
    );

    assign scan_begin = (st == SQ_IDLE) && start && (|ch_mask);
    assign frame_go   = (st == SQ_ISSUE);

    always_comb begin
        if (found)
            frame_word = make_cmd(pick_idx, rng_q);
        else if (single_q && trail == 2'd0)
            frame_word = make_cmd(cur_ch, rng_q);
        else
            frame_word = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            pend     <= '0;
            rng_q    <= 1'b0;
            single_q <= 1'b0;
            trail    <= '0;
            cur_ch   <= '0;
            busy     <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (scan_begin) begin
                        pend     <= ch_mask;
                        rng_q    <= wide_range;
                        single_q <= ($countones(ch_mask) == 1);
                        trail    <= '0;
                        busy     <= 1'b1;
                        st       <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    if (found) begin
                        pend[pick_idx] <= 1'b0;
                        cur_ch         <= pick_idx;
                    end else begin
                        trail <= trail + 1'b1;
                    end
                    st <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (frame_done)
                        st <= (trail == 2'd2) ? SQ_FIN : SQ_ISSUE;
                end
                default: begin
                    busy <= 1'b0;
                    st   <= SQ_IDLE;
                end
            endcase
        end
    end

    adc_scan_spi #(.SCLK_HALF(SCLK_HALF), .CS_GAP(CS_GAP)) u_spi (
        .clk     (clk),
        .rst     (rst),
        .go      (frame_go),
        .tx_word (frame_word),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .miso    (miso),
        .done    (frame_done),
        .rx_word (frame_rx)
    );

    adc_scan_resp #(.SAMPLE_W(SAMPLE_W)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .scan_begin (scan_begin),
        .frame_done (frame_done),
        .rx_word    (frame_rx),
        .frame_chan (cur_ch),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .smp_chan   (smp_chan),
        .smp_err    (smp_err)
    );

    p_valid_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> busy);

    p_idle_no_frame_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && st != SQ_IDLE) |=> $stable(rng_q));

endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [15:0]  ch_mask = '0;
    logic         wide_range = 1'b0;
    logic         busy, sclk, cs_n, mosi;
    logic         miso = 1'b0;
    logic         smp_valid;
    logic [W-1:0] smp_data;
    logic [3:0]   smp_chan;
    logic         smp_err;

    always #10 clk = ~clk;

    adc_scan_seq #(.SAMPLE_W(W), .SCLK_HALF(2), .CS_GAP(2)) u_dut (
        .clk(clk), .rst(rst), .start(start), .ch_mask(ch_mask),
        .wide_range(wide_range), .busy(busy), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_chan(smp_chan), .smp_err(smp_err)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model
    logic [15:0] cmds [0:31];
    int          n_frames = 0;
    int          scan_id = 0;
    int          bad_idx = -1;
    logic [15:0] s_tx, s_rx;

    function automatic int sample_of(input int ch, input int k, input int sid);
        return (ch * 173 + k * 29 + sid * 7 + 5) % 4096;
    endfunction

    function automatic logic [15:0] resp_of(input int k);
        logic [3:0] ch;
        logic [3:0] echo;
        int v;
        ch   = cmds[k][10:7];
        echo = (k == bad_idx) ? (ch ^ 4'h9) : ch;
        v    = sample_of(ch, k, scan_id) & ((1 << W) - 1);
        return {echo, 12'(v << (12 - W))};
    endfunction

    always @(negedge cs_n) begin
        s_tx = (n_frames >= 2) ? resp_of(n_frames - 2) : 16'h0;
        s_rx = '0;
        miso = s_tx[15];
    end
    always @(posedge sclk) if (!cs_n) s_rx = {s_rx[14:0], mosi};
    always @(negedge sclk) if (!cs_n) begin
        s_tx = {s_tx[14:0], 1'b0};
        miso = s_tx[15];
    end
    always @(posedge cs_n) begin
        if (n_frames < 32) cmds[n_frames] = s_rx;
        n_frames++;
    end

    // Output and port monitor
    int  cyc = 0;
    int  n_out = 0;
    int  o_ch [0:31];
    int  o_d  [0:31];
    int  o_e  [0:31];
    int  last_valid_cyc = 0, busy_fall_cyc = 0, busy_rises = 0;
    bit  p_busy = 0, p_sclk = 0, p_mosi = 0, p_cs = 1, had_frame = 0;
    int  gap = 0, min_gap = 1000, sp_viol = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (smp_valid) begin
                if (n_out < 32) begin
                    o_ch[n_out] = smp_chan;
                    o_d[n_out]  = smp_data;
                    o_e[n_out]  = smp_err;
                end
                n_out++;
                last_valid_cyc = cyc;
            end
            if (p_busy && !busy) busy_fall_cyc = cyc;
            if (!p_busy && busy) busy_rises++;
            if (cs_n && sclk) sp_viol++;
            if (sclk && p_sclk && (mosi != p_mosi)) sp_viol++;
            if (cs_n) gap++;
            else begin
                if (p_cs && had_frame && gap < min_gap) min_gap = gap;
                if (p_cs) had_frame = 1;
                gap = 0;
            end
            p_busy = busy; p_sclk = sclk; p_mosi = mosi; p_cs = cs_n;
        end
    end

    always @(posedge clk) begin
        if (cyc > 190000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [15:0] exp_cmd(input int ch, input bit rng);
        return 16'((1 << 12) | (1 << 11) | (ch << 7) | (int'(rng) << 6));
    endfunction

    task automatic run_scan(input logic [15:0] mask, input bit rng, input int bad, input bit interfere);
        int exp_ch [0:15];
        int n = 0;
        int t = 0;
        for (int c = 0; c < 16; c++) if (mask[c]) begin exp_ch[n] = c; n++; end
        n_frames = 0; n_out = 0; bad_idx = bad; scan_id++;
        @(negedge clk);
        ch_mask = mask; wide_range = rng; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == (n != 0), (n != 0) ? "R8 busy rise" : "R9 busy low", busy, n != 0);
        if (interfere) begin
            ch_mask = ~mask; wide_range = !rng;
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy && t < 5000) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk);
        if (n == 0) begin
            check(n_frames == 0, "R9 frames", n_frames, 0);
            check(n_out == 0, "R9 samples", n_out, 0);
            return;
        end
        check(n_frames == n + 2, (n == 1) ? "R4 frame count" : "R3 frame count", n_frames, n + 2);
        for (int i = 0; i < n; i++)
            check(cmds[i] == exp_cmd(exp_ch[i], rng), "R1 R2 R10 command", cmds[i], exp_cmd(exp_ch[i], rng));
        if (n == 1) begin
            check(cmds[1] == exp_cmd(exp_ch[0], rng), "R4 filler repeat", cmds[1], exp_cmd(exp_ch[0], rng));
            check(cmds[2] == 16'h0, "R4 last zero", cmds[2], 0);
        end else begin
            check(cmds[n] == 16'h0, "R3 trail zero", cmds[n], 0);
            check(cmds[n+1] == 16'h0, "R3 trail zero", cmds[n+1], 0);
        end
        check(n_out == n, "R6 sample count", n_out, n);
        for (int i = 0; i < n && i < n_out; i++) begin
            int ev;
            ev = sample_of(exp_ch[i], i, scan_id) & ((1 << W) - 1);
            check(o_ch[i] == exp_ch[i], "R6 R10 channel", o_ch[i], exp_ch[i]);
            check(o_d[i] == ev, "R6 data", o_d[i], ev);
            check(o_e[i] == int'(i == bad), "R7 error flag", o_e[i], int'(i == bad));
        end
        check(busy_fall_cyc == last_valid_cyc + 1, "R8 busy fall", busy_fall_cyc, last_valid_cyc + 1);
    endtask

    initial begin
        logic [15:0] lf;
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && cs_n == 1'b1 && sclk == 1'b0 && smp_valid == 1'b0,
              "R8 reset state", {busy, cs_n, sclk, smp_valid}, 4'b0100);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        for (int c = 0; c < 16; c++) run_scan(16'(1 << c), c[0], -1, 1'b0);
        run_scan(16'hFFFF, 1'b1, -1, 1'b0);
        run_scan(16'hAAAA, 1'b0, -1, 1'b0);
        run_scan(16'h5555, 1'b1, 3, 1'b0);
        run_scan(16'h8001, 1'b0, 1, 1'b0);
        run_scan(16'h0003, 1'b1, 0, 1'b0);
        run_scan(16'hFFFF, 1'b0, 15, 1'b0);
        run_scan(16'h0010, 1'b1, 0, 1'b0);
        run_scan(16'h00C3, 1'b0, -1, 1'b1);
        run_scan(16'h0000, 1'b1, -1, 1'b0);
        lf = 16'hACE1;
        for (int s = 0; s < 12; s++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run_scan(lf, lf[4], (s % 3 == 0) ? s % 5 : -1, 1'b0);
        end
        begin
            int r0;
            r0 = busy_rises;
            run_scan(16'h0000, 1'b0, -1, 1'b0);
            check(busy_rises == r0, "R9 no busy pulse", busy_rises - r0, 0);
        end
        check(sp_viol == 0, "R5 clock and data timing", sp_viol, 0);
        check(min_gap >= 2, "R5 chip select gap", min_gap, 2);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule